// File: doc/BRIEF.md
# Two-Step Survivor Traceback with Output Reordering

This block recovers decoded bits from a survivor memory in which every trellis state owns a 2-bit entry per memory word. Each entry records the best two-step path into that state, so one read moves the traceback back two trellis steps. A start strobe supplies the starting state and the newest written word. The walk reads one entry per cycle and steps the word index back by one on each read. The next state is formed directly from the entry that has just been read.

The traceback uses plain truncation. Any starting state is accepted, and the first `MERGE_READS` reads only bring the walk to the depth where all survivor paths are taken to have merged. Their bits are thrown away. The next `BLOCK_READS` reads yield `2*BLOCK_READS` decoded bits in newest-first order. These bits are stacked and then shifted out one per cycle, oldest first. A busy flag refuses new starts while a walk is running. It drops as soon as the finished block starts to drain, so the next walk can run while the previous block is still being shifted out.

Top module: `survivor_traceback`

## Requirements
- R1: While reset is held and on the first cycle after it, `busy`, `rd_en` and `out_valid` are all 0.
- R2: When `start` is sampled high with `busy` low, the next cycle issues the first read, with `rd_addr` = {`start_word`, `start_state`}.
- R3: Every later read of the same walk is issued on the next consecutive cycle. Its word field is the previous word minus one, modulo 2^`WORD_W`. Its state field is ((previous state << 2) | `rd_data`) mod 2^`STATE_W`, where `rd_data` is the entry returned for the previous read in that same cycle.
- R4: A walk issues exactly `MERGE_READS + BLOCK_READS` reads, and `rd_en` is never high while `busy` is low.
- R5: The entries returned for the first `MERGE_READS` reads of a walk have no effect on the decoded output.
- R6: In the cycle after the data of the last read returns, `out_valid` rises and stays high for exactly `2*BLOCK_READS` cycles. The output runs from the last kept read back to the first kept read. For each read, bit 0 of its entry (the older step) comes out first and bit 1 (the newer step) second.
- R7: `busy` is high from the first read cycle through the cycle in which the last read's data returns. A `start` pulse seen while `busy` is high has no effect.
- R8: `busy` falls only in a cycle where `out_valid` is high, meaning the finished block has begun draining.
- R9: A walk started while the previous block is still draining does not disturb that block's output. Its own block follows the previous one without a gap in the bit order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Request a new traceback |
| start_state | input | STATE_W | Trellis state the walk begins from |
| start_word | input | WORD_W | Newest written survivor word |
| busy | output | 1 | Walk in progress; start is ignored |
| rd_en | output | 1 | Survivor memory read strobe |
| rd_addr | output | WORD_W+STATE_W | Read address {word, state} |
| rd_data | input | 2 | Entry returned one cycle after the read: bit 1 newer step, bit 0 older step |
| out_bit | output | 1 | Decoded bit, oldest first |
| out_valid | output | 1 | out_bit carries a decoded bit |

## Verification
The bench looks for wrong feedback in the address chain. A design that used a stale entry, or shifted the state the wrong way, would wander through the wrong states at once. A design that forgot the word wrap would fail on a walk starting at word 0. It tests the merge boundary and the pair order inside each read: an off-by-one kept-read count, or swapped pair bits, shows up as one bit displaced at the ends of the block. It also sends start pulses in the middle of a walk, starts a walk the moment busy drops, and holds start high. A design that accepted a start early, or let a new walk overwrite the block being drained, would corrupt the output stream.

// File: rtl/survivor_traceback.sv
module survivor_traceback #(
  parameter int STATE_W     = 7,
  parameter int WORD_W      = 6,
  parameter int MERGE_READS = 21,
  parameter int BLOCK_READS = 16
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      start,
  input  logic [STATE_W-1:0]        start_state,
  input  logic [WORD_W-1:0]         start_word,
  output logic                      busy,
  output logic                      rd_en,
  output logic [WORD_W+STATE_W-1:0] rd_addr,
  input  logic [1:0]                rd_data,
  output logic                      out_bit,
  output logic                      out_valid
);

  localparam int TOTAL = MERGE_READS + BLOCK_READS;
  localparam int BB    = 2 * BLOCK_READS;
  localparam int CW    = $clog2(TOTAL + 1);
  localparam int DW    = $clog2(BB + TOTAL + 1);
  localparam int PW    = $clog2(BB);

  localparam logic [CW-1:0] TOTAL_C = CW'(TOTAL);
  localparam logic [CW-1:0] LAST_C  = CW'(TOTAL - 1);
  localparam logic [CW-1:0] MERGE_C = CW'(MERGE_READS);
  localparam logic [DW-1:0] BB_D    = DW'(BB);
  localparam logic [DW-1:0] SLACK_D = DW'(TOTAL);

  logic               tracing, first, vld_q;
  logic [CW-1:0]      issued, recv;
  logic [STATE_W-1:0] cur_state, addr_state;
  logic [WORD_W-1:0]  cur_word, addr_word;
  logic [BB-1:0]      stk, obuf;
  logic [DW-1:0]      drain_left;
  logic [PW-1:0]      push_pos;
  logic               accept, keep, last_recv;

  assign addr_state = first ? cur_state : {cur_state[STATE_W-3:0], rd_data};
  assign addr_word  = first ? cur_word  : cur_word - 1'b1;
  assign rd_addr    = {addr_word, addr_state};
  assign rd_en      = tracing && (issued != TOTAL_C);

  assign busy      = tracing || (drain_left > SLACK_D);
  assign accept    = start && !busy;
  assign keep      = vld_q && (recv >= MERGE_C);
  assign last_recv = vld_q && (recv == LAST_C);
  assign push_pos  = PW'(recv - MERGE_C) << 1;

  assign out_bit   = obuf[BB-1];
  assign out_valid = (drain_left != '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tracing   <= 1'b0;
      first     <= 1'b0;
      vld_q     <= 1'b0;
      issued    <= '0;
      recv      <= '0;
      cur_state <= '0;
      cur_word  <= '0;
    end else begin
      vld_q <= rd_en;
      if (accept) begin
        tracing   <= 1'b1;
        first     <= 1'b1;
        issued    <= '0;
        recv      <= '0;
        cur_state <= start_state;
        cur_word  <= start_word;
      end else if (tracing) begin
        if (rd_en) begin
          first     <= 1'b0;
          issued    <= issued + 1'b1;
          cur_state <= addr_state;
          cur_word  <= addr_word;
        end
        if (vld_q) recv <= recv + 1'b1;
        if (last_recv) tracing <= 1'b0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stk <= '0;
    end else if (keep) begin
      stk[push_pos +: 2] <= {rd_data[0], rd_data[1]};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      obuf       <= '0;
      drain_left <= '0;
    end else if (last_recv) begin
      obuf       <= {rd_data[0], rd_data[1], stk[BB-3:0]};
      drain_left <= BB_D;
    end else if (drain_left != '0) begin
      obuf       <= obuf << 1;
      drain_left <= drain_left - 1'b1;
    end
  end

endmodule

// File: rtl/survivor_traceback_chk.sv
module survivor_traceback_chk #(
  parameter int STATE_W = 7,
  parameter int WORD_W  = 6
) (
  input logic                      clk,
  input logic                      rst_n,
  input logic                      start,
  input logic [STATE_W-1:0]        start_state,
  input logic [WORD_W-1:0]         start_word,
  input logic                      busy,
  input logic                      rd_en,
  input logic [WORD_W+STATE_W-1:0] rd_addr,
  input logic [1:0]                rd_data,
  input logic                      out_valid
);

  a_r2_first_addr: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> rd_en && rd_addr == {$past(start_word), $past(start_state)});

  a_r3_state_chain: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && $past(rd_en) && $past(busy)) |->
      rd_addr[STATE_W-1:0] == STATE_W'(({1'b0, $past(rd_addr[STATE_W-1:0])} << 2) | (STATE_W+1)'(rd_data)));

  a_r3_word_step: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && $past(rd_en) && $past(busy)) |->
      rd_addr[WORD_W+STATE_W-1:STATE_W] == $past(rd_addr[WORD_W+STATE_W-1:STATE_W]) - 1'b1);

  a_r4_read_needs_busy: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en |-> busy);

  a_r8_release_on_drain: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> out_valid);

endmodule

bind survivor_traceback survivor_traceback_chk #(.STATE_W(STATE_W), .WORD_W(WORD_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .start_state(start_state),
  .start_word(start_word), .busy(busy), .rd_en(rd_en), .rd_addr(rd_addr),
  .rd_data(rd_data), .out_valid(out_valid)
);

// File: tb/survivor_traceback_bench.sv
module survivor_traceback_bench;
  localparam int CLK_PERIOD = 10;
  localparam int STATE_W = 7;
  localparam int WORD_W  = 6;
  localparam int MERGE   = 21;
  localparam int BLOCK   = 16;
  localparam int TOTAL   = MERGE + BLOCK;
  localparam int BB      = 2 * BLOCK;
  localparam int AW      = WORD_W + STATE_W;

  logic clk = 0, rst_n = 0, start = 0;
  logic [STATE_W-1:0] start_state = '0;
  logic [WORD_W-1:0]  start_word = '0;
  logic busy, rd_en, out_bit, out_valid;
  logic [AW-1:0] rd_addr;
  logic [1:0] rd_data = '0;

  survivor_traceback #(.STATE_W(STATE_W), .WORD_W(WORD_W), .MERGE_READS(MERGE), .BLOCK_READS(BLOCK))
    u_survivor_traceback (.clk(clk), .rst_n(rst_n), .start(start), .start_state(start_state),
      .start_word(start_word), .busy(busy), .rd_en(rd_en), .rd_addr(rd_addr),
      .rd_data(rd_data), .out_bit(out_bit), .out_valid(out_valid));

  always #(CLK_PERIOD/2) clk = ~clk;

  int tests = 0, fails = 0, cyc = 0, seed = 0, s0 = -1, last_out = -1;
  int exp_addr[int];
  bit exp_out[int];
  bit b2b = 0;

  function automatic logic [1:0] ram_val(int a, int sd);
    int h;
    h = a * 29 + (a >> 4) * 7 + sd * 11;
    return 2'(h) ^ 2'(h >> 2);
  endfunction

  always @(posedge clk) if (rd_en) rd_data <= ram_val(int'(rd_addr), seed);

  function automatic bit model_busy(int n);
    return s0 >= 0 && n >= s0 + 1 && n <= s0 + 1 + TOTAL;
  endfunction

  task automatic schedule(int n);
    int st, w, d;
    bit nb[$];
    bit ob[$];
    st = int'(start_state); w = int'(start_word);
    for (int i = 0; i < TOTAL; i++) begin
      exp_addr[n + 1 + i] = w * (1 << STATE_W) + st;
      d = int'(ram_val(w * (1 << STATE_W) + st, seed));
      if (i >= MERGE) begin nb.push_back(d[1]); ob.push_back(d[0]); end
      st = ((st << 2) | d) & ((1 << STATE_W) - 1);
      w = (w - 1) & ((1 << WORD_W) - 1);
    end
    for (int k = 0; k < BLOCK; k++) begin
      exp_out[n + 2 + TOTAL + 2*k]     = ob[BLOCK - 1 - k];
      exp_out[n + 2 + TOTAL + 2*k + 1] = nb[BLOCK - 1 - k];
    end
    s0 = n;
    last_out = n + 1 + TOTAL + BB;
  endtask

  always @(posedge clk) begin
    if (!rst_n) cyc = 0;
    else begin
      if (start && !model_busy(cyc)) schedule(cyc);
      cyc = cyc + 1;
    end
  end

  task automatic chk(bit ok, string tag, int act, int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s cycle %0d: actual %0h expected %0h", tag, cyc, act, exp);
    end
  endtask

  always @(negedge clk) if (rst_n) begin
    bit ee, ev;
    string ot;
    ee = exp_addr.exists(cyc);
    chk(rd_en == ee, (cyc == s0 + 1) ? "R2 read strobe" : "R4 read strobe", int'(rd_en), int'(ee));
    if (ee && rd_en)
      chk(int'(rd_addr) == exp_addr[cyc], (cyc == s0 + 1) ? "R2 first address" : "R3 chained address",
          int'(rd_addr), exp_addr[cyc]);
    chk(busy == model_busy(cyc), "R7/R8 busy", int'(busy), int'(model_busy(cyc)));
    ev = exp_out.exists(cyc);
    ot = b2b ? "R6/R9 output" : "R5/R6 output";
    chk(out_valid == ev, ot, int'(out_valid), int'(ev));
    if (ev && out_valid) chk(out_bit == exp_out[cyc], ot, int'(out_bit), int'(exp_out[cyc]));
  end

  task automatic wait_drained();
    while (cyc <= last_out + 1) @(negedge clk);
  endtask

  task automatic pulse(int st, int w);
    start_state = STATE_W'(st); start_word = WORD_W'(w); start = 1;
    @(negedge clk); start = 0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(!busy && !rd_en && !out_valid, "R1 reset state", int'({busy, rd_en, out_valid}), 0);
    rst_n = 1;
    @(negedge clk);
    chk(!busy && !rd_en && !out_valid, "R1 after reset", int'({busy, rd_en, out_valid}), 0);

    seed = 1; pulse(0, 0);              // word wrap through 0
    wait_drained();

    seed = 2; pulse(127, 40);
    repeat (5) @(negedge clk);
    pulse(3, 9);                        // R7: ignored while busy
    repeat (10) @(negedge clk);
    pulse(64, 1);                       // R7: ignored while busy
    wait_drained();

    seed = 3; pulse(85, 63);
    while (busy) @(negedge clk);
    b2b = 1;                            // R9: start as soon as busy drops
    pulse(42, 17);
    wait_drained();
    b2b = 0;

    seed = 4; start_state = 7'd99; start_word = 6'd5; start = 1;
    repeat (3 * (TOTAL + 2)) @(negedge clk);
    start = 0;
    wait_drained();

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 20000);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule